// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Output Coding

This block runs a 10-bit successive-approximation search against an analog comparator and a binary-weighted DAC that sit outside it. A start request latches the input mode. The block then drives one trial code per clock to the DAC. Each clock it reads back one comparator bit and settles one bit of the code, working from the most significant bit down to the least.

When the last bit is settled, the search code is written to the result register in the coding the latched mode selects:
- Single-ended conversions always give straight binary.
- Differential unipolar conversions give straight binary, clamped to zero when the input is negative.
- Differential bipolar conversions give two's complement.

The sign of a differential input is taken from the comparator bit on the clock that accepts the start request. At that point the external comparator is expected to be comparing the two inputs against each other. During the search, a comparator bit of 1 means the analog input is at or above the trial level.

Top module: `sar_conv_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, busy_o, done_o, result_o and trial_o are all zero.
- R2: A start_i sampled high while idle makes busy_o high from the next cycle on, for exactly 10 cycles.
- R3: The first trial code is 10'h200, which has only the most significant bit set. On each busy cycle the trial bit under test is kept when cmp_i is 1 and cleared when cmp_i is 0, and the next lower bit is then set.
- R4: done_o is high for exactly one cycle, the first cycle in which busy_o is low again, and result_o carries the new result in that same cycle.
- R5: With single_i = 1 the result is the search code as straight binary, whatever bipolar_i and the sign sample are.
- R6: With single_i = 0 and bipolar_i = 0 the result is the search code as straight binary. If cmp_i was 1 on the accepting clock, meaning the differential input is negative, the result is 0.
- R7: With single_i = 0 and bipolar_i = 1 the search runs in offset binary, and the result is the search code with its most significant bit inverted. This gives two's complement, so an input at mid-scale reads 0.
- R8: A start_i while busy_o is high is ignored, and so are changes to single_i or bipolar_i after the accepting clock. The conversion keeps its length and its coding, and no second conversion follows.
- R9: After done_o, result_o holds its value and trial_o holds the final search code until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Conversion request, sampled while idle |
| single_i | input | 1 | 1 selects single-ended input, 0 selects differential |
| bipolar_i | input | 1 | 1 selects bipolar coding for differential input |
| cmp_i | input | 1 | Comparator bit: the sign on the accepting clock, then input at or above trial during busy |
| trial_o | output | 10 | Trial code to the DAC |
| busy_o | output | 1 | High while the search runs |
| done_o | output | 1 | One-cycle pulse when the result updates |
| result_o | output | 10 | Coded conversion result |

## Verification
busy_o is due one cycle after the clock that samples start_i. It falls 10 cycles later, and done_o and the new result_o appear in that same cycle. The bench drives inputs on the falling edge and samples on the next falling edge, so each check reads the value from one specific rising edge. The bench models the comparator as a combinational function of trial_o and busy_o, which gives a decision on every busy edge. It counts busy cycles one falling edge at a time, and it checks result_o on the exact falling edge where busy_o is first low.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int unsigned DEF_BITS = 10;

    typedef struct packed {
        logic single;
        logic bipolar;
    } conv_mode_t;

    typedef enum logic [1:0] {
        CODE_STRAIGHT = 2'd0,
        CODE_ZERO     = 2'd1,
        CODE_TWOS     = 2'd2
    } coding_t;

    function automatic coding_t pick_coding(input conv_mode_t m, input logic neg);
        if (m.single)       return CODE_STRAIGHT;
        else if (m.bipolar) return CODE_TWOS;
        else if (neg)       return CODE_ZERO;
        else                return CODE_STRAIGHT;
    endfunction

endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
    import sar_seq_pkg::*;
#(
    parameter int unsigned NBITS = DEF_BITS,
    localparam int unsigned IDX_W = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  conv_mode_t       mode_in,
    input  logic             cmp,
    output logic             accept,
    output logic             busy,
    output logic             last,
    output logic             done,
    output logic [IDX_W-1:0] idx,
    output conv_mode_t       mode_q,
    output logic             sign_q
);
    assign accept = start && !busy;
    assign last   = busy && (idx == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            idx    <= '0;
            mode_q <= '0;
            sign_q <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy   <= 1'b1;
                idx    <= IDX_W'(NBITS - 1);
                mode_q <= mode_in;
                sign_q <= cmp;
            end else if (busy) begin
                if (idx == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    idx <= idx - 1'b1;
                end
            end
        end
    end

    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);
    p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_ends_busy_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));
    p_mode_held_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(mode_q) && $stable(sign_q)));
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
    import sar_seq_pkg::*;
#(
    parameter int unsigned NBITS = DEF_BITS,
    localparam int unsigned IDX_W = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic             last,
    input  logic [IDX_W-1:0] idx,
    input  logic             cmp,
    output logic [NBITS-1:0] trial,
    output logic [NBITS-1:0] decided
);
    localparam logic [NBITS-1:0] MSB_ONLY = {1'b1, {(NBITS-1){1'b0}}};

    logic [NBITS-1:0] next_trial;

    always_comb begin
        decided = trial;
        for (int i = 0; i < NBITS; i++) begin
            if (i == int'(idx) && !cmp) decided[i] = 1'b0;
        end
        next_trial = decided;
        for (int i = 0; i < NBITS; i++) begin
            if (i + 1 == int'(idx)) next_trial[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                trial <= '0;
        else if (load)          trial <= MSB_ONLY;
        else if (step && last)  trial <= decided;
        else if (step)          trial <= next_trial;
    end

    p_first_trial_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> (trial == MSB_ONLY));
    p_trial_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(trial));
endmodule

// File: rtl/sar_coder.sv
module sar_coder
    import sar_seq_pkg::*;
#(
    parameter int unsigned NBITS = DEF_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             last,
    input  conv_mode_t       mode,
    input  logic             sign,
    input  logic [NBITS-1:0] code,
    output logic [NBITS-1:0] result
);
    coding_t          kind;
    logic [NBITS-1:0] coded;

    always_comb begin
        kind = pick_coding(mode, sign);
        unique case (kind)
            CODE_ZERO: coded = '0;
            CODE_TWOS: coded = {~code[NBITS-1], code[NBITS-2:0]};
            default:   coded = code;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       result <= '0;
        else if (last) result <= coded;
    end

    p_clamp_neg_r6: assert property (@(posedge clk) disable iff (rst)
        (last && !mode.single && !mode.bipolar && sign) |=> (result == '0));
    p_single_plain_r5: assert property (@(posedge clk) disable iff (rst)
        (last && mode.single) |=> (result == $past(code)));
    p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !last |=> $stable(result));
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_seq_pkg::*;
#(
    parameter int unsigned NBITS = DEF_BITS,
    localparam int unsigned IDX_W = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             single_i,
    input  logic             bipolar_i,
    input  logic             cmp_i,
    output logic [NBITS-1:0] trial_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [NBITS-1:0] result_o
);
    conv_mode_t       mode_in, mode_q;
    logic             accept, busy, last, done, sign_q;
    logic [IDX_W-1:0] idx;
    logic [NBITS-1:0] decided;

    assign mode_in = '{single: single_i, bipolar: bipolar_i};

    sar_ctrl #(.NBITS(NBITS)) ctrl_i (
        .clk(clk), .rst(rst), .start(start_i), .mode_in(mode_in), .cmp(cmp_i),
        .accept(accept), .busy(busy), .last(last), .done(done), .idx(idx),
        .mode_q(mode_q), .sign_q(sign_q)
    );

    sar_trial_reg #(.NBITS(NBITS)) trial_i (
        .clk(clk), .rst(rst), .load(accept), .step(busy), .last(last),
        .idx(idx), .cmp(cmp_i), .trial(trial_o), .decided(decided)
    );

    sar_coder #(.NBITS(NBITS)) coder_i (
        .clk(clk), .rst(rst), .last(last), .mode(mode_q), .sign(sign_q),
        .code(decided), .result(result_o)
    );

    assign busy_o = busy;
    assign done_o = done;

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (start_i && busy_o) |=> (trial_o != {1'b1, {(NBITS-1){1'b0}}} || !busy_o || $past(trial_o) == trial_o));
endmodule

// File: tb/sar_conv_seq_tb_top.sv
module sar_conv_seq_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NB = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, single_i = 1'b0, bipolar_i = 1'b0;
    logic cmp_i;
    logic [NB-1:0] trial_o, result_o;
    logic busy_o, done_o;

    logic [NB-1:0] ain = '0;
    logic          neg = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign cmp_i = busy_o ? (ain >= trial_o) : neg;

    sar_conv_seq #(.NBITS(NB)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .single_i(single_i),
        .bipolar_i(bipolar_i), .cmp_i(cmp_i), .trial_o(trial_o),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    typedef struct packed {
        logic          se;
        logic          bip;
        logic          ng;
        logic [NB-1:0] a;
        logic [NB-1:0] exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, 10'h000, 10'h000},
        '{1'b1, 1'b0, 1'b0, 10'h3FF, 10'h3FF},
        '{1'b1, 1'b1, 1'b1, 10'h155, 10'h155},
        '{1'b1, 1'b0, 1'b0, 10'h201, 10'h201},
        '{1'b0, 1'b0, 1'b0, 10'h2AA, 10'h2AA},
        '{1'b0, 1'b0, 1'b1, 10'h2AA, 10'h000},
        '{1'b0, 1'b1, 1'b0, 10'h200, 10'h000},
        '{1'b0, 1'b1, 1'b0, 10'h000, 10'h200},
        '{1'b0, 1'b1, 1'b1, 10'h3FF, 10'h1FF},
        '{1'b0, 1'b1, 1'b0, 10'h1FF, 10'h3FF}
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Runs one conversion; with disturb set, a second start and a mode flip occur mid-run.
    task automatic run_conv(input logic se, input logic bip, input logic ng,
                            input logic [NB-1:0] a, input logic [NB-1:0] exp,
                            input string req, input logic disturb);
        int cnt = 0;
        @(negedge clk);
        single_i = se; bipolar_i = bip; neg = ng; ain = a; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1, "R2 busy after start", busy_o, 1);
        check(trial_o === 10'h200, "R3 first trial", trial_o, 10'h200);
        while (busy_o === 1'b1 && cnt < 20) begin
            @(negedge clk);
            cnt++;
            if (disturb && cnt == 3) begin
                start_i = 1'b1; single_i = ~se; bipolar_i = ~bip;
            end
            if (disturb && cnt == 4) start_i = 1'b0;
        end
        check(cnt == 10, "R2 busy length", cnt, 10);
        check(done_o === 1'b1, "R4 done with result", done_o, 1);
        check(result_o === exp, req, result_o, exp);
        @(negedge clk);
        check(done_o === 1'b0, "R4 done one cycle", done_o, 0);
        if (disturb) check(busy_o === 1'b0, "R8 no second conversion", busy_o, 0);
    endtask

    initial begin
        #(200000 * CLK_PERIOD);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy_o === 0 && done_o === 0 && result_o === 0 && trial_o === 0,
              "R1 reset state", {busy_o, done_o, result_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy_o === 0 && done_o === 0 && result_o === 0 && trial_o === 0,
              "R1 after reset", {busy_o, done_o, result_o}, 0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = VECS[i].se ? "R5 single-ended" : (VECS[i].bip ? "R7 bipolar" : "R6 unipolar diff");
            run_conv(VECS[i].se, VECS[i].bip, VECS[i].ng, VECS[i].a, VECS[i].exp, tag, 1'b0);
        end

        // R8: start and mode flip during busy are ignored
        run_conv(1'b0, 1'b1, 1'b0, 10'h100, 10'h300, "R8 coding kept", 1'b1);

        // R9: result and final trial hold while idle
        single_i = 1'b1; bipolar_i = 1'b0; ain = 10'h055;
        repeat (3) @(negedge clk);
        check(result_o === 10'h300, "R9 result held", result_o, 10'h300);
        check(trial_o === 10'h100, "R9 trial held", trial_o, 10'h100);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule